// File: doc/BRIEF.md
# UART Autobaud Handshake Controller

The block sets a serial link's bit rate from the line itself. After reset it watches the receive line for a zero character from the host. A zero character in 8N1 format is one continuous low stretch: the start bit and eight zero data bits, 9 bit times in all. The block counts the system clocks in that stretch. It divides the count by nine and rounds the result, which gives the clocks per bit.

That divisor is loaded into a small internal transmitter and receiver. The transmitter then sends one acknowledge byte of value 0x00 at the new rate. The receiver then waits for a confirm byte of value 0x55 from the host.

If the confirm byte arrives intact, the rate is locked and the divisor is frozen. Any other byte, or a byte whose stop bit is low, puts the block in an error state. The block does not retry on its own: only a reset clears that state. A low stretch that is too short or too long is discarded, and the block waits for the next falling edge.

Top module: `autobaud_ctrl`

## Requirements
- R1: After an accepted low stretch, `tx_o` sends the acknowledge byte 0x00 as an 8N1 frame. The frame is a low start bit, eight data bits sent LSB first and a high stop bit, and each bit lasts `divisor_o` clocks.
- R2: `divisor_o` becomes round(N/9), computed as (N+4)/9 with the remainder discarded. N is the number of clocks for which the synchronized receive line stayed low.
- R3: A low stretch shorter than MIN_LOW clocks, or longer than MAX_LOW clocks, is rejected. After a rejected stretch no byte is sent and `divisor_o` keeps its value. Both bounds are inclusive for acceptance.
- R4: Exactly one acknowledge byte is sent per calibration. No other byte ever appears on `tx_o`.
- R5: When 0x55 is received with a high stop bit, sampled at mid-bit, `locked_o` goes to 1 and `error_o` stays 0. `locked_o` is 0 before that point.
- R6: When the received confirm byte is any value other than 0x55, `error_o` goes to 1 and `locked_o` stays 0.
- R7: When the confirm byte has a low stop bit, `error_o` goes to 1, even if the data bits equal 0x55.
- R8: Once `error_o` is 1 it stays 1 until reset, and no new calibration starts. A later 0x55 does not set `locked_o`.
- R9: While `locked_o` is 1 it stays 1 and `divisor_o` holds steady, whatever arrives on `rx_i`.
- R10: Reset state: `tx_o` is 1, `locked_o` is 0, `error_o` is 0 and `divisor_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line from the host, idle high |
| tx_o | output | 1 | Serial transmit line to the host, idle high |
| divisor_o | output | DIV_W | Derived clocks per bit |
| locked_o | output | 1 | The rate has been confirmed |
| error_o | output | 1 | The confirm byte was wrong or badly framed |

## Verification
A wrong measurement count or a wrong rounding step shows directly as a wrong `divisor_o`, within about twenty clocks of the rising edge of the line. It also shows as an acknowledge frame whose bit cells have the wrong length, which breaks decoding of the byte at the bench's expected rate.

A faulty state sequence appears at the ports in one of three ways:
- an acknowledge byte that is missing or repeated on `tx_o`;
- a divisor that changes after a rejected stretch;
- a `locked_o` or `error_o` that differs from the value the confirm byte calls for, one bit time after that byte's stop bit.

// File: rtl/ab_pkg.sv
package ab_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_FALL,
    ST_MEASURE,
    ST_DIVIDE,
    ST_SEND_ACK,
    ST_WAIT_CONF,
    ST_LOCKED,
    ST_ERROR
  } ab_state_e;

  localparam int unsigned BITS_IN_LOW = 9;
endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ab_cdiv.sv
// Restoring division by a constant, with a rounding offset added up front
module ab_cdiv #(
  parameter int unsigned NW  = 17,
  parameter int unsigned DEN = 9,
  parameter int unsigned QW  = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [NW-1:0] dividend_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);
  localparam int unsigned RW = $clog2(DEN + 1) + 1;
  localparam int unsigned IW = $clog2(NW + 1);

  logic [NW-1:0] dvd_q, quo_q;
  logic [RW-1:0] rem_q, rem_sh;
  logic [IW-1:0] idx_q;
  logic          busy_q, ge;

  assign rem_sh = {rem_q[RW-2:0], dvd_q[NW-1]};
  assign ge     = rem_sh >= RW'(DEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        dvd_q  <= dividend_i;
        quo_q  <= '0;
        rem_q  <= '0;
        idx_q  <= IW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? rem_sh - RW'(DEN) : rem_sh;
        quo_q <= {quo_q[NW-2:0], ge};
        dvd_q <= dvd_q << 1;
        idx_q <= idx_q - IW'(1);
        if (idx_q == IW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q[QW-1:0];
endmodule

// File: rtl/ab_utx.sv
module ab_utx #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       data_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tx_o,
  output logic             done_o
);
  logic [8:0]       sh_q;
  logic [3:0]       n_q;
  logic [DIV_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      n_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tx_o   <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_q) begin
        tx_o   <= 1'b0;
        sh_q   <= {1'b1, data_i};
        n_q    <= '0;
        cnt_q  <= div_i - DIV_W'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - DIV_W'(1);
        end else if (n_q == 4'd9) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end else begin
          tx_o  <= sh_q[0];
          sh_q  <= {1'b1, sh_q[8:1]};
          n_q   <= n_q + 4'd1;
          cnt_q <= div_i - DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ab_urx.sv
module ab_urx #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fall_i,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             ferr_o
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  rx_state_e        st_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (st_q != RX_IDLE && cnt_q != '0) begin
        cnt_q <= cnt_q - DIV_W'(1);
      end else begin
        unique case (st_q)
          RX_IDLE: if (en_i && fall_i) begin
            st_q  <= RX_START;
            cnt_q <= (div_i >> 1) - DIV_W'(1);
          end
          RX_START: begin
            // a glitch that is gone by mid start bit is not a frame
            st_q  <= rx_i ? RX_IDLE : RX_DATA;
            cnt_q <= div_i - DIV_W'(1);
            bit_q <= '0;
          end
          RX_DATA: begin
            data_o <= {rx_i, data_o[7:1]};
            bit_q  <= bit_q + 3'd1;
            cnt_q  <= div_i - DIV_W'(1);
            if (bit_q == 3'd7) st_q <= RX_STOP;
          end
          RX_STOP: begin
            valid_o <= 1'b1;
            ferr_o  <= !rx_i;
            st_q    <= RX_IDLE;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/autobaud_ctrl.sv
module autobaud_ctrl
  import ab_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned DIV_W     = 12,
  parameter int unsigned MIN_LOW   = 144,   // keep >= 18 so half a bit is at least one clock
  parameter int unsigned MAX_LOW   = 24300,
  parameter logic [7:0]  ACK_BYTE  = 8'h00,
  parameter logic [7:0]  CONF_BYTE = 8'h55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  output logic             tx_o,
  output logic [DIV_W-1:0] divisor_o,
  output logic             locked_o,
  output logic             error_o
);
  localparam int unsigned NW = CNT_W + 1;
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_LOW);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LOW);

  ab_state_e        st_q;
  logic             rx_s, rx_q, fall, rise;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q, quo;
  logic             div_start_q, div_done, tx_start_q, tx_done;
  logic             rx_valid, rx_ferr;
  logic [7:0]       rx_data;
  logic [NW-1:0]    dividend;

  ab_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_q <= 1'b1;
    else         rx_q <= rx_s;
  end

  assign fall     = rx_q & ~rx_s;
  assign rise     = ~rx_q & rx_s;
  assign dividend = {1'b0, cnt_q} + NW'(BITS_IN_LOW / 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_WAIT_FALL;
      cnt_q       <= '0;
      div_q       <= '0;
      div_start_q <= 1'b0;
      tx_start_q  <= 1'b0;
    end else begin
      div_start_q <= 1'b0;
      tx_start_q  <= 1'b0;
      unique case (st_q)
        ST_WAIT_FALL: if (fall) begin
          cnt_q <= CNT_W'(1);
          st_q  <= ST_MEASURE;
        end
        ST_MEASURE: begin
          if (rise) begin
            if (cnt_q >= MIN_C) begin
              st_q        <= ST_DIVIDE;
              div_start_q <= 1'b1;
            end else begin
              st_q <= ST_WAIT_FALL;
            end
          end else if (cnt_q == MAX_C) begin
            st_q <= ST_WAIT_FALL;      // too long; wait for a fresh edge
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DIVIDE: if (div_done) begin
          div_q      <= quo;
          tx_start_q <= 1'b1;
          st_q       <= ST_SEND_ACK;
        end
        ST_SEND_ACK: if (tx_done) st_q <= ST_WAIT_CONF;
        ST_WAIT_CONF: if (rx_valid) begin
          st_q <= (!rx_ferr && rx_data == CONF_BYTE) ? ST_LOCKED : ST_ERROR;
        end
        ST_LOCKED: st_q <= ST_LOCKED;
        ST_ERROR:  st_q <= ST_ERROR;
        default:   st_q <= ST_ERROR;
      endcase
    end
  end

  ab_cdiv #(.NW(NW), .DEN(BITS_IN_LOW), .QW(DIV_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start_q),
    .dividend_i(dividend), .done_o(div_done), .quo_o(quo)
  );

  ab_utx #(.DIV_W(DIV_W)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start_q), .data_i(ACK_BYTE),
    .div_i(div_q), .tx_o(tx_o), .done_o(tx_done)
  );

  ab_urx #(.DIV_W(DIV_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(st_q == ST_WAIT_CONF), .fall_i(fall),
    .rx_i(rx_s), .div_i(div_q), .valid_o(rx_valid), .data_o(rx_data),
    .ferr_o(rx_ferr)
  );

  assign divisor_o = div_q;
  assign locked_o  = (st_q == ST_LOCKED);
  assign error_o   = (st_q == ST_ERROR);
endmodule

// File: rtl/autobaud_ctrl_chk.sv
module autobaud_ctrl_chk #(
  parameter int unsigned DIV_W   = 12,
  parameter int unsigned MIN_LOW = 144,
  parameter int unsigned MAX_LOW = 24300
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_o,
  input logic [DIV_W-1:0] divisor_o,
  input logic             locked_o,
  input logic             error_o
);
  localparam logic [DIV_W-1:0] DIV_LO = DIV_W'((MIN_LOW + 4) / 9);
  localparam logic [DIV_W-1:0] DIV_HI = DIV_W'((MAX_LOW + 4) / 9);

  AST_LOCK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(locked_o && error_o)); // R5

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(divisor_o)); // R9

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o); // R9

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o); // R8

  AST_TX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divisor_o == '0) |-> tx_o); // R4

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(divisor_o) |-> (divisor_o >= DIV_LO && divisor_o <= DIV_HI)); // R3
endmodule

bind autobaud_ctrl autobaud_ctrl_chk #(
  .DIV_W(DIV_W), .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_o(tx_o), .divisor_o(divisor_o),
  .locked_o(locked_o), .error_o(error_o)
);

// File: tb/autobaud_ctrl_bench.sv
module autobaud_ctrl_bench;
  localparam int unsigned DIV_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx = 1'b1;
  logic             tx_o;
  logic [DIV_W-1:0] divisor_o;
  logic             locked_o, error_o;

  int n_chk = 0, n_fail = 0;
  int mon_bit = 16;
  int mon_seen = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  autobaud_ctrl #(.CNT_W(16), .DIV_W(DIV_W), .MIN_LOW(72), .MAX_LOW(400)) u_autobaud_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx_o),
    .divisor_o(divisor_o), .locked_o(locked_o), .error_o(error_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: decode tx frames at the expected bit period and score them
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx_o == 1'b0) begin
        logic [7:0] got;
        logic st, sp;
        repeat (mon_bit / 2) @(negedge clk);
        st = tx_o;
        for (int i = 0; i < 8; i++) begin
          repeat (mon_bit) @(negedge clk);
          got[i] = tx_o;
        end
        repeat (mon_bit) @(negedge clk);
        sp = tx_o;
        mon_seen++;
        chk(st == 1'b0 && sp == 1'b1, "R1 framing", {30'd0, st, sp}, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected tx byte", int'(got), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(got == e, "R1 ack value", int'(got), int'(e));
        end
      end
    end
  end

  task automatic do_reset();
    rx = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.delete();
    mon_seen = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic drive_low(input int n);
    @(negedge clk);
    rx = 1'b0;
    repeat (n) @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] d, input int b, input bit stop_ok);
    @(negedge clk);
    rx = 1'b0;
    repeat (b) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i];
      repeat (b) @(negedge clk);
    end
    rx = stop_ok;
    repeat (b) @(negedge clk);
    rx = 1'b1;
    repeat (2 * b + 10) @(negedge clk);
  endtask

  task automatic reject(input int n, input string req);
    int seen0;
    logic [DIV_W-1:0] d0;
    seen0 = mon_seen;
    d0 = divisor_o;
    drive_low(n);
    repeat (400) @(negedge clk);
    chk(mon_seen == seen0, {req, " no ack"}, mon_seen, seen0);
    chk(divisor_o == d0, {req, " divisor kept"}, int'(divisor_o), int'(d0));
  endtask

  task automatic calib(input int low, input int exp_div, input string req);
    int seen0;
    seen0 = mon_seen;
    mon_bit = exp_div;
    exp_q.push_back(8'h00);
    drive_low(low);
    repeat (40 + 12 * exp_div + 80) @(negedge clk);
    chk(int'(divisor_o) == exp_div, {req, " divisor"}, int'(divisor_o), exp_div);
    chk(mon_seen == seen0 + 1, "R4 one ack", mon_seen, seen0 + 1);
    chk(exp_q.size() == 0, "R1 ack received", exp_q.size(), 0);
  endtask

  initial begin
    do_reset();
    chk(tx_o == 1'b1, "R10 tx idle", int'(tx_o), 1);
    chk(locked_o == 1'b0, "R10 locked", int'(locked_o), 0);
    chk(error_o == 1'b0, "R10 error", int'(error_o), 0);
    chk(divisor_o == '0, "R10 divisor", int'(divisor_o), 0);

    // case A: short reject, nominal lock, locked ignores input
    reject(40, "R3 short");
    calib(144, 16, "R2 exact");
    chk(locked_o == 1'b0, "R5 not locked before confirm", int'(locked_o), 0);
    send_byte(8'h55, 16, 1'b1);
    chk(locked_o == 1'b1, "R5 locked", int'(locked_o), 1);
    chk(error_o == 1'b0, "R5 no error", int'(error_o), 0);
    send_byte(8'h00, 16, 1'b1);
    send_byte(8'hAA, 16, 1'b1);
    drive_low(200);
    repeat (300) @(negedge clk);
    chk(locked_o == 1'b1, "R9 stays locked", int'(locked_o), 1);
    chk(divisor_o == 16, "R9 divisor held", int'(divisor_o), 16);
    chk(mon_seen == 1, "R4 no further tx", mon_seen, 1);

    // case B: long reject, rounding, max bound
    do_reset();
    reject(500, "R3 long");
    reject(401, "R3 above max");
    calib(400, 44, "R3 max accepted");
    do_reset();
    calib(150, 17, "R2 rounding");
    send_byte(8'h55, 17, 1'b1);
    chk(locked_o == 1'b1, "R5 locked at 17", int'(locked_o), 1);

    // case C: wrong confirm byte, then error sticks
    do_reset();
    calib(144, 16, "R2 exact");
    send_byte(8'hAA, 16, 1'b1);
    chk(error_o == 1'b1, "R6 error", int'(error_o), 1);
    chk(locked_o == 1'b0, "R6 not locked", int'(locked_o), 0);
    send_byte(8'h55, 16, 1'b1);
    drive_low(144);
    repeat (400) @(negedge clk);
    chk(error_o == 1'b1, "R8 error sticks", int'(error_o), 1);
    chk(locked_o == 1'b0, "R8 no lock", int'(locked_o), 0);
    chk(mon_seen == 1, "R8 no new ack", mon_seen, 1);

    // case D: framing error on confirm
    do_reset();
    calib(135, 15, "R2 div15");
    send_byte(8'h55, 15, 1'b0);
    chk(error_o == 1'b1, "R7 framing error", int'(error_o), 1);
    chk(locked_o == 1'b0, "R7 not locked", int'(locked_o), 0);

    // case E: min bound
    do_reset();
    reject(71, "R3 below min");
    calib(72, 8, "R3 min accepted");
    send_byte(8'h55, 8, 1'b1);
    chk(locked_o == 1'b1, "R5 locked at 8", int'(locked_o), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule